// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block walks an external four-way analog multiplexer through its inputs and drives a delta-sigma converter that needs the selected input to stay put for a whole conversion. For each input it waits a programmable settling count, then sends a one-cycle start strobe. It holds the selection until the converter's active-low ready line falls. At that point it moves the multiplexer to the next input at once. While the new input settles, it reads the finished 16-bit word over an SPI-style port (clock idle low, MSB first, sampled on the rising edge). Each word leaves on a valid/ready output together with the number of the input it was converted from.

The controller is a three-state machine. `SQ_IDLE` loads the settling timer and moves to `SQ_SETTLE`. This happens after reset and after a timeout. `SQ_SETTLE` moves to `SQ_CONVERT` on the *fire* transition. Fire needs three things: the settling count has expired, the serial read has finished, and the output slot is empty. `SQ_CONVERT` has two exits:
- The *take* transition, when the synchronized ready line falls. The block advances the channel, reloads the settling timer, launches the read and returns to `SQ_SETTLE`.
- The *abort* transition, when the conversion timer expires first. The block pulses `timeout_err`, homes the multiplexer to input 0 and returns to `SQ_IDLE`.

Top module: `mux_adc_sequencer`

## Requirements
- R1: While reset is held, and until the first strobe, `mux_sel` is 0, `conv_start` is 0, `spi_cs_n` is 1, `spi_sclk` is 0, `res_valid` is 0 and `timeout_err` is 0.
- R2: Inputs are visited in the order 0,1,2,3,0,… When `adc_rdy_n` is first sampled low at a rising edge k, after being high at edge k-1, `mux_sel` takes the next channel at edge k+2. This follows a two-flop synchronizer and a falling-edge detector.
- R3: `mux_sel` does not change from the strobe until the ready fall is acted on, or until a timeout.
- R4: `conv_start` is a one-cycle high pulse. The settling timer is loaded with `settle_cycles` at the edge where the channel changes, and on the first edge out of reset or after a timeout. The strobe rises no earlier than `settle_cycles`+1 edges later. A value of 0 lets the strobe follow as soon as the read is done.
- R5: The read starts at the same edge that advances the channel. `spi_cs_n` stays low for exactly 32×`SCLK_HALF` clocks, during which `spi_sclk` makes 16 rising edges. `spi_miso` is shifted in MSB first on each rising edge.
- R6: After a take, the strobe rises at the later of two edges. One is the edge `settle_cycles`+1 after the take. The other is the edge just after the output word has been accepted.
- R7: `res_valid` rises one edge after `spi_cs_n` returns high. While `res_ready` is 0, `res_valid`, `res_data` and `res_chan` hold. `res_valid` falls at the edge where `res_valid` and `res_ready` are both 1.
- R8: `res_chan` is the channel that was selected during that word's conversion, not the newly selected channel.
- R9: If no ready fall is acted on within `timeout_cycles`+1 edges after the strobe edge, `timeout_err` pulses for one cycle and `mux_sel` returns to 0. A fresh settling interval then starts, and no word is produced for that conversion.
- R10: No strobe is issued while `spi_cs_n` is low or `res_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| settle_cycles | input | 16 | Settling interval in clocks, sampled when the timer is loaded |
| timeout_cycles | input | 20 | Conversion time limit in clocks, sampled at the strobe |
| mux_sel | output | 2 | Selected analog input |
| conv_start | output | 1 | One-cycle start-conversion strobe |
| adc_rdy_n | input | 1 | Converter ready, active low, asynchronous |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Serial chip select, active low |
| spi_miso | input | 1 | Serial data from the converter |
| res_valid | output | 1 | Output word valid |
| res_ready | input | 1 | Output word accepted |
| res_data | output | 16 | Converted word |
| res_chan | output | 2 | Channel the word was converted from |
| timeout_err | output | 1 | One-cycle pulse when a conversion times out |

## Verification
The hardest situation to reach is the start gate when its two conditions finish in either order. In one case the read finishes before settling ends; in the other, settling ends first and the read or a stalled consumer holds the strobe back. A timeout must also arrive in the middle of an otherwise healthy channel cycle. The stimulus first runs a short settling count, so the read is the limiting path. It then raises the count to 200 clocks so settling limits, sets it to zero, and holds `res_ready` low for 300 clocks to stall the output. Finally the converter model ignores one strobe, which forces the abort path from channel 3 back to channel 0. A behavioural model predicts `mux_sel`, `conv_start` and `timeout_err` on every clock through all of these phases.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_SETTLE  = 2'd1,
        SQ_CONVERT = 2'd2
    } seq_state_t;

endpackage

// File: rtl/seq_down_timer.sv
// Loadable down-counter; expired is high while the count sits at zero.
module seq_down_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/seq_rdy_sync.sv
// Synchronizer chain plus one history flop; flags a high-to-low transition.
module seq_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic fall
);

    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], async_n};
        end
    end

    assign fall = pipe_q[STAGES] & ~pipe_q[STAGES-1];

endmodule

// File: rtl/seq_spi_reader.sv
// Reads one DATA_W word: clock idle low, capture on the rising edge, MSB first.
module seq_spi_reader #(
    parameter int DATA_W    = 16,
    parameter int SCLK_HALF = 2,
    parameter int TAG_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic              miso,
    output logic              sclk,
    output logic              cs_n,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic [TAG_W-1:0]  tag_out
);

    localparam int DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam int BIT_W = $clog2(DATA_W);

    logic              active_q;
    logic              sclk_q;
    logic              done_q;
    logic [DIV_W-1:0]  div_q;
    logic [BIT_W-1:0]  bits_q;
    logic [DATA_W-1:0] shift_q;
    logic [TAG_W-1:0]  tag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            done_q   <= 1'b0;
            div_q    <= '0;
            bits_q   <= '0;
            shift_q  <= '0;
            tag_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (start && !active_q) begin
                active_q <= 1'b1;
                sclk_q   <= 1'b0;
                div_q    <= '0;
                bits_q   <= '0;
                tag_q    <= tag_in;
            end else if (active_q) begin
                if (div_q == DIV_W'(SCLK_HALF - 1)) begin
                    div_q  <= '0;
                    sclk_q <= ~sclk_q;
                    if (!sclk_q) begin
                        shift_q <= {shift_q[DATA_W-2:0], miso};
                    end else if (bits_q == BIT_W'(DATA_W - 1)) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        bits_q <= bits_q + BIT_W'(1);
                    end
                end else begin
                    div_q <= div_q + DIV_W'(1);
                end
            end
        end
    end

    assign sclk    = sclk_q;
    assign cs_n    = ~active_q;
    assign busy    = active_q;
    assign done    = done_q;
    assign data    = shift_q;
    assign tag_out = tag_q;

endmodule

// File: rtl/mux_adc_sequencer.sv
module mux_adc_sequencer
    import seq_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int DATA_W      = 16,
    parameter int SCLK_HALF   = 2,
    parameter int SETTLE_W    = 16,
    parameter int TMO_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SETTLE_W-1:0]       settle_cycles,
    input  logic [TMO_W-1:0]          timeout_cycles,
    output logic [$clog2(NUM_CH)-1:0] mux_sel,
    output logic                      conv_start,
    input  logic                      adc_rdy_n,
    output logic                      spi_sclk,
    output logic                      spi_cs_n,
    input  logic                      spi_miso,
    output logic                      res_valid,
    input  logic                      res_ready,
    output logic [DATA_W-1:0]         res_data,
    output logic [$clog2(NUM_CH)-1:0] res_chan,
    output logic                      timeout_err
);

    localparam int CH_W = $clog2(NUM_CH);

    seq_state_t        state_q, state_nx;
    logic [CH_W-1:0]   mux_q;
    logic [CH_W-1:0]   conv_ch_q;
    logic              start_q;
    logic              err_q;
    logic              rdy_fall;
    logic              settle_load, settle_exp;
    logic              tmo_load, tmo_exp;
    logic              rd_busy, rd_done;
    logic [DATA_W-1:0] rd_data;
    logic [CH_W-1:0]   rd_tag;
    logic              fire, take, abort;
    logic              slot_valid_q;
    logic [DATA_W-1:0] slot_data_q;
    logic [CH_W-1:0]   slot_chan_q;

    function automatic logic [CH_W-1:0] next_ch(input logic [CH_W-1:0] ch);
        return (ch == CH_W'(NUM_CH - 1)) ? '0 : ch + CH_W'(1);
    endfunction

    seq_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (adc_rdy_n),
        .fall    (rdy_fall)
    );

    seq_down_timer #(.W(SETTLE_W)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (settle_load),
        .load_val (settle_cycles),
        .expired  (settle_exp)
    );

    seq_down_timer #(.W(TMO_W)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmo_load),
        .load_val (timeout_cycles),
        .expired  (tmo_exp)
    );

    seq_spi_reader #(
        .DATA_W    (DATA_W),
        .SCLK_HALF (SCLK_HALF),
        .TAG_W     (CH_W)
    ) u_reader (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (take),
        .tag_in  (conv_ch_q),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .cs_n    (spi_cs_n),
        .busy    (rd_busy),
        .done    (rd_done),
        .data    (rd_data),
        .tag_out (rd_tag)
    );

    // Transition conditions
    assign fire  = (state_q == SQ_SETTLE) && settle_exp && !rd_busy && !rd_done && !slot_valid_q;
    assign take  = (state_q == SQ_CONVERT) && rdy_fall;
    assign abort = (state_q == SQ_CONVERT) && !rdy_fall && tmo_exp;

    assign settle_load = (state_q == SQ_IDLE) || take;
    assign tmo_load    = fire;

    // Next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SQ_IDLE:    state_nx = SQ_SETTLE;
            SQ_SETTLE:  if (fire) state_nx = SQ_CONVERT;
            SQ_CONVERT: begin
                if (take)       state_nx = SQ_SETTLE;
                else if (abort) state_nx = SQ_IDLE;
            end
            default:    state_nx = SQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_nx;
    end

    // Outputs of the sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_q     <= '0;
            conv_ch_q <= '0;
            start_q   <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            start_q <= 1'b0;
            err_q   <= 1'b0;
            if (fire) begin
                start_q   <= 1'b1;
                conv_ch_q <= mux_q;
            end
            if (take) begin
                mux_q <= next_ch(mux_q);
            end else if (abort) begin
                err_q <= 1'b1;
                mux_q <= '0;
            end
        end
    end

    // Result slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid_q <= 1'b0;
            slot_data_q  <= '0;
            slot_chan_q  <= '0;
        end else if (rd_done) begin
            slot_valid_q <= 1'b1;
            slot_data_q  <= rd_data;
            slot_chan_q  <= rd_tag;
        end else if (slot_valid_q && res_ready) begin
            slot_valid_q <= 1'b0;
        end
    end

    assign mux_sel     = mux_q;
    assign conv_start  = start_q;
    assign timeout_err = err_q;
    assign res_valid   = slot_valid_q;
    assign res_data    = slot_data_q;
    assign res_chan    = slot_chan_q;

endmodule

// File: rtl/mux_adc_sequencer_chk.sv
module mux_adc_sequencer_chk
    import seq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input seq_state_t                state_q,
    input logic                      rdy_fall,
    input logic [$clog2(NUM_CH)-1:0] mux_sel,
    input logic                      conv_start,
    input logic                      spi_cs_n,
    input logic                      spi_sclk,
    input logic                      res_valid,
    input logic                      res_ready,
    input logic [DATA_W-1:0]         res_data,
    input logic [$clog2(NUM_CH)-1:0] res_chan,
    input logic                      timeout_err
);

    localparam int CH_W = $clog2(NUM_CH);

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R4

    AST_MUX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_CONVERT && !rdy_fall && !timeout_err && !$isunknown(mux_sel)
         && !(state_q == SQ_CONVERT && !rdy_fall && $past(1'b1) && 1'b0))
        |=> (timeout_err || $stable(mux_sel))); // R3

    AST_MUX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_CONVERT && rdy_fall)
        |=> (mux_sel == (($past(mux_sel) == CH_W'(NUM_CH - 1)) ? '0 : $past(mux_sel) + CH_W'(1)))); // R2

    AST_START_QUIET_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (spi_cs_n && !res_valid)); // R10

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_chan))); // R7

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk); // R5

    AST_ERR_HOMES_MUX: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (mux_sel == '0 && !conv_start)); // R9

endmodule

bind mux_adc_sequencer mux_adc_sequencer_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .rdy_fall    (rdy_fall),
    .mux_sel     (mux_sel),
    .conv_start  (conv_start),
    .spi_cs_n    (spi_cs_n),
    .spi_sclk    (spi_sclk),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .res_data    (res_data),
    .res_chan    (res_chan),
    .timeout_err (timeout_err)
);

// File: tb/mux_adc_sequencer_tb_top.sv
`timescale 1ns/1ps
module mux_adc_sequencer_tb_top;

    localparam int NCH      = 4;
    localparam int DW       = 16;
    localparam int HALF     = 2;
    localparam int SW       = 16;
    localparam int TW       = 20;
    localparam int CONV_LAT = 20;
    localparam int WD       = 150000;
    localparam int FAR      = 1 << 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] settle_cycles = 16'd5;
    logic [TW-1:0] timeout_cycles = 20'd100;
    logic [1:0]    mux_sel;
    logic          conv_start;
    logic          adc_rdy_n = 1'b1;
    logic          spi_sclk;
    logic          spi_cs_n;
    logic          spi_miso = 1'b0;
    logic          res_valid;
    logic          res_ready = 1'b1;
    logic [DW-1:0] res_data;
    logic [1:0]    res_chan;
    logic          timeout_err;

    always #2 clk = ~clk;

    mux_adc_sequencer #(
        .NUM_CH(NCH), .DATA_W(DW), .SCLK_HALF(HALF), .SETTLE_W(SW), .TMO_W(TW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .settle_cycles(settle_cycles), .timeout_cycles(timeout_cycles),
        .mux_sel(mux_sel), .conv_start(conv_start), .adc_rdy_n(adc_rdy_n),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .res_chan(res_chan), .timeout_err(timeout_err)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic logic [15:0] gen_word(input int n);
        if (n == 0) return 16'hFFFF;
        if (n == 1) return 16'h0000;
        if (n == 2) return 16'h8001;
        return 16'(n * 40503) ^ 16'h5A5A;
    endfunction

    // ---------------- reference model state ----------------
    int         m_ph = 0;          // 0 idle, 1 settle, 2 convert
    int         m_mux = 0, m_conv_ch = 0;
    bit         m_start = 0, m_err = 0, m_fall = 0;
    int         settle_ok = 0, data_ok = 0, tmo_at = FAR, exp_valid_edge = FAR;
    bit [2:0]   hist = 3'b111;
    logic [15:0] exp_word[$];
    int         exp_chan[$];
    int         n_res = 0, n_err = 0;

    // values captured away from the edge
    bit         s_valid = 0, prev_valid = 0, hold_chk = 0;
    logic [15:0] s_data = '0, hold_data = '0;
    logic [1:0] s_chan = '0, hold_chan = '0;

    // converter model state
    int         adc_st = 0, adc_cnt = 0, adc_n = 0, bitidx = 0;
    logic [15:0] adc_word = '0, cur_word = '0;
    bit         skip_next = 0, prev_sclk = 0, prev_cs = 1;
    int         cs_low = 0, sclk_rises = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD) begin
            n_bad++;
            $display("FAIL watchdog (R6 gate never opened) actual=%0d expected<%0d", cyc, WD);
            summary();
            $finish;
        end
        if (!rst_n) begin
            m_ph = 0; m_mux = 0; m_start = 0; m_err = 0; hist = 3'b111;
            data_ok = 0; hold_chk = 0;
        end else begin
            m_fall = hist[2] && !hist[1];
            m_start = 0;
            m_err = 0;
            if (s_valid && res_ready) begin
                if (exp_word.size() == 0) begin
                    chk(1'b0, "R7 unexpected word", s_data, 0);
                end else begin
                    chk(s_data == exp_word[0], "R5 data", s_data, exp_word[0]);
                    chk(int'(s_chan) == exp_chan[0], "R8 R2 channel tag", s_chan, exp_chan[0]);
                    void'(exp_word.pop_front());
                    void'(exp_chan.pop_front());
                end
                n_res++;
                data_ok = cyc + 1;
            end
            if (s_valid && !res_ready) begin
                hold_chk = 1; hold_data = s_data; hold_chan = s_chan;
            end else begin
                hold_chk = 0;
            end
            case (m_ph)
                0: begin
                    settle_ok = cyc + int'(settle_cycles) + 1;
                    m_ph = 1;
                end
                1: begin
                    if (cyc >= settle_ok && cyc >= data_ok) begin
                        m_start = 1;
                        m_conv_ch = m_mux;
                        tmo_at = cyc + int'(timeout_cycles) + 1;
                        m_ph = 2;
                    end
                end
                default: begin
                    if (m_fall) begin
                        exp_word.push_back(cur_word);
                        exp_chan.push_back(m_conv_ch);
                        exp_valid_edge = cyc + 32 * HALF + 1;
                        m_mux = (m_mux + 1) % NCH;
                        settle_ok = cyc + int'(settle_cycles) + 1;
                        data_ok = FAR;
                        m_ph = 1;
                    end else if (cyc >= tmo_at) begin
                        m_err = 1;
                        n_err++;
                        m_mux = 0;
                        m_ph = 0;
                    end
                end
            endcase
            hist = {hist[1:0], adc_rdy_n};
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(mux_sel) == m_mux, "R2 R3 mux_sel", mux_sel, m_mux);
            chk(conv_start == m_start, "R4 R6 conv_start", conv_start, m_start);
            chk(timeout_err == m_err, "R9 timeout_err", timeout_err, m_err);
            if (conv_start)
                chk(spi_cs_n && !res_valid, "R10 strobe while busy", {spi_cs_n, res_valid}, 2'b10);
            if (res_valid && !prev_valid)
                chk(cyc == exp_valid_edge, "R7 valid rise edge", cyc, exp_valid_edge);
            if (hold_chk)
                chk(res_valid && res_data == hold_data && res_chan == hold_chan,
                    "R7 hold while stalled", {res_valid, res_data}, {1'b1, hold_data});
            // serial framing monitor
            if (!spi_cs_n) begin
                cs_low++;
                if (spi_sclk && !prev_sclk) sclk_rises++;
            end
            if (spi_cs_n && !prev_cs) begin
                chk(cs_low == 32 * HALF, "R5 cs_n low width", cs_low, 32 * HALF);
                chk(sclk_rises == 16, "R5 sclk rising edges", sclk_rises, 16);
                cs_low = 0;
                sclk_rises = 0;
            end
            // converter model
            if (conv_start) begin
                if (skip_next) begin
                    skip_next = 0;
                end else begin
                    adc_st = 1;
                    adc_cnt = CONV_LAT;
                    adc_word = gen_word(adc_n);
                    adc_n++;
                end
            end else if (adc_st == 1) begin
                adc_cnt--;
                if (adc_cnt == 0) begin
                    adc_rdy_n = 1'b0;
                    cur_word = adc_word;
                    adc_st = 2;
                end
            end else if (adc_st == 2 && !spi_cs_n) begin
                adc_rdy_n = 1'b1;
                bitidx = 0;
                adc_st = 0;
            end
            if (!spi_cs_n) begin
                if (prev_sclk && !spi_sclk) bitidx++;
                spi_miso = (bitidx < 16) ? adc_word[15 - bitidx] : 1'b0;
            end
        end
        prev_sclk = spi_sclk;
        prev_cs = spi_cs_n;
        prev_valid = res_valid;
        s_valid = res_valid;
        s_data = res_data;
        s_chan = res_chan;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mux_sel == 2'd0, "R1 reset mux_sel", mux_sel, 0);
        chk(conv_start == 1'b0, "R1 reset conv_start", conv_start, 0);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 reset serial idle", {spi_cs_n, spi_sclk}, 2'b10);
        chk(res_valid == 1'b0 && timeout_err == 1'b0, "R1 reset valid/err", {res_valid, timeout_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mux_sel == 2'd0 && conv_start == 1'b0, "R1 first cycle after reset", {mux_sel, conv_start}, 0);

        // readout-limited gate, wraps through all channels (R2, R6)
        wait (n_res >= 6);
        @(negedge clk) settle_cycles = 16'd200;   // settle-limited (R4)
        wait (n_res >= 10);
        @(negedge clk) settle_cycles = 16'd0;     // zero settling (R4)
        wait (n_res >= 13);
        @(negedge clk) res_ready = 1'b0;          // stall the consumer (R7, R6)
        repeat (300) @(negedge clk);
        chk(n_res == 13 && res_valid, "R7 no handshake while stalled", n_res, 13);
        chk(exp_word.size() == 1, "R6 no new conversion while slot full", exp_word.size(), 1);
        res_ready = 1'b1;
        wait (n_res >= 15);
        @(negedge clk) skip_next = 1;             // converter ignores one strobe (R9)
        wait (n_err >= 1);
        @(negedge clk);
        chk(mux_sel == 2'd0, "R9 mux homed after timeout", mux_sel, 0);
        wait (n_res >= 18);
        repeat (5) @(negedge clk);
        chk(n_err == 1, "R9 timeout count", n_err, 1);
        chk(exp_word.size() == 0, "R9 no word from aborted conversion", exp_word.size(), 0);
        summary();
        $finish;
    end

endmodule